// File: doc/BRIEF.md
# Byte FIFO with Packet Status Flags

This block buffers payload bytes between a radio modem's datapath and its host. It holds up to 66 bytes in a first-in, first-out store with one write port and one read port. Next to the store it keeps an eight-bit status word. The word reports the fill state of the store: full, empty, and above a programmable threshold. It also holds a sticky overrun marker, the packet-sent, payload-ready and CRC-good events of the current transfer, and a latched low-battery alarm.

The surrounding modem supplies several inputs. It reports the current radio mode (sleep, standby, transmit or receive) and pulses a strobe when a packet finishes, with the CRC verdict alongside that strobe. It also passes on the CRC enable and auto-clear-off settings and the output of a battery comparator. Software clears the sticky bits by writing ones into the status word. Writing a one to the overrun position also discards everything in the store, so the FIFO is ready at once for the next packet.

Top module: `pkt_fifo_status`

## Requirements
- R1: `status[7]` is 1 exactly when 66 bytes are stored. A write while 66 bytes are stored is discarded, even if a read happens in the same cycle, and the stored bytes are unchanged.
- R2: `status[6]` is 1 exactly when no byte is stored.
- R3: `status[5]` is 1 exactly when the stored byte count is strictly greater than `thresh`. It follows a change of `thresh` without a clock edge.
- R4: `status[4]` (overrun) is set when a write arrives while 66 bytes are stored, unless `mode` is sleep (mode codes: 0 sleep, 1 standby, 2 transmit, 3 receive). Once set, it stays set, and a status write with bit 4 at 0 leaves it set.
- R5: A status write (`irq_wr`) with `irq_wdata[4]`=1 empties the store and clears the overrun, payload-ready and CRC-good bits at that edge. It overrides a read or write in the same cycle. The next write is accepted normally.
- R6: `status[3]` (packet sent) is set by `pkt_done` in transmit mode, stays set while in transmit mode, and clears at the first edge outside transmit mode.
- R7: `status[2]` (payload ready) is set by `pkt_done` in receive mode when `crc_en`=0, or `crc_autoclr_off`=1, or `crc_good`=1. It is not set by `pkt_done` in any other mode.
- R8: `status[1]` (CRC good) is set by `pkt_done` with `crc_good`=1 in receive mode.
- R9: Payload ready and CRC good clear at the edge where the store becomes empty. A set in the same cycle wins over that clear.
- R10: `status[0]` (low battery) is set while `batt_low`=1. It is cleared only by a status write with `irq_wdata[0]`=1, and a set in the same cycle wins over that clear.
- R11: Bytes are read in the order they were written, and `rd_data` is updated at the edge that takes `rd_en`. A read from an empty store returns 0 and leaves the read position unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | Radio mode: 0 sleep, 1 standby, 2 transmit, 3 receive |
| wr_en | input | 1 | Write a byte into the store |
| wr_data | input | 8 | Byte to write |
| rd_en | input | 1 | Read a byte from the store |
| rd_data | output | 8 | Byte read, registered |
| thresh | input | 7 | Level threshold, compared with strict greater-than |
| pkt_done | input | 1 | Packet finished (sent in transmit, last byte in receive) |
| crc_good | input | 1 | CRC verdict, valid with `pkt_done` |
| crc_en | input | 1 | CRC checking enabled |
| crc_autoclr_off | input | 1 | Payload ready is raised regardless of the CRC verdict |
| batt_low | input | 1 | Battery comparator reports a low voltage |
| irq_wr | input | 1 | Software write to the status word |
| irq_wdata | input | 8 | Write data: 1 in bit 4 flushes, 1 in bit 0 clears low battery |
| status | output | 8 | {full, empty, level, overrun, sent, payload ready, CRC good, low battery} |

## Verification
Every write, read, strobe and status write takes effect at the clock edge that samples it. The fill bits, the sticky bits and `rd_data` therefore show the result right after that same edge. The level bit follows the threshold input with no clock at all. The bench drives its inputs one time unit after a rising edge and checks each result one time unit after the next rising edge. For threshold changes it checks one time unit after the change, while the store is idle.

// File: rtl/pfs_pkg.sv
package pfs_pkg;

    typedef enum logic [1:0] {
        MODE_SLEEP = 2'd0,
        MODE_STBY  = 2'd1,
        MODE_TX    = 2'd2,
        MODE_RX    = 2'd3
    } radio_mode_e;

    typedef struct packed {
        logic full;
        logic empty;
        logic level;
        logic overrun;
        logic pkt_sent;
        logic payload_rdy;
        logic crc_ok;
        logic low_bat;
    } fifo_status_t;

    localparam int unsigned W1C_FLUSH_BIT  = 4;
    localparam int unsigned W1C_LOWBAT_BIT = 0;

    // Payload may be released when CRC is off, ignored, or passed.
    function automatic logic payload_allowed(input logic crc_en,
                                             input logic autoclr_off,
                                             input logic crc_good);
        return !crc_en || autoclr_off || crc_good;
    endfunction

endpackage

// File: rtl/pfs_store.sv
module pfs_store #(
    parameter int DEPTH = 66,
    parameter int DW    = 8,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_en,
    input  logic          flush,
    input  logic          ovr_allowed,
    output logic [DW-1:0] rd_data,
    output logic [CW-1:0] count,
    output logic          drain,
    output logic          ovr_evt
);

    localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);
    localparam logic [CW-1:0] CAP      = CW'(DEPTH);

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic [CW-1:0] cnt_d;
    logic          is_full, is_empty, wr_ok, rd_ok;

    function automatic logic [AW-1:0] advance(input logic [AW-1:0] p);
        return (p == LAST_IDX) ? '0 : p + 1'b1;
    endfunction

    assign is_full  = (count == CAP);
    assign is_empty = (count == '0);
    assign wr_ok    = wr_en && !is_full && !flush;
    assign rd_ok    = rd_en && !is_empty && !flush;
    assign ovr_evt  = wr_en && is_full && !flush && ovr_allowed;

    always_comb begin
        cnt_d = count;
        if (flush) begin
            cnt_d = '0;
        end else begin
            case ({wr_ok, rd_ok})
                2'b10:   cnt_d = count + 1'b1;
                2'b01:   cnt_d = count - 1'b1;
                default: cnt_d = count;
            endcase
        end
    end

    assign drain = (cnt_d == '0);

    always_ff @(posedge clk) begin
        if (wr_ok) begin
            mem[wptr] <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr    <= '0;
            rptr    <= '0;
            count   <= '0;
            rd_data <= '0;
        end else if (flush) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
            if (rd_en) begin
                rd_data <= '0;
            end
        end else begin
            if (wr_ok) begin
                wptr <= advance(wptr);
            end
            if (rd_ok) begin
                rptr <= advance(rptr);
            end
            count <= cnt_d;
            if (rd_en) begin
                rd_data <= rd_ok ? mem[rptr] : '0;
            end
        end
    end

    assert_count_bound_R1: assert property (@(posedge clk) disable iff (rst)
        count <= CAP);

    assert_full_discard_R1: assert property (@(posedge clk) disable iff (rst)
        (is_full && wr_en && !rd_en && !flush) |=> (count == CAP && $stable(wptr)));

    assert_empty_read_R11: assert property (@(posedge clk) disable iff (rst)
        (rd_en && is_empty && !flush) |=> (rd_data == '0 && $stable(rptr)));

    assert_flush_empties_R5: assert property (@(posedge clk) disable iff (rst)
        flush |=> (count == '0));

endmodule

// File: rtl/pfs_flags.sv
module pfs_flags
    import pfs_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  radio_mode_e mode,
    input  logic        pkt_done,
    input  logic        crc_good,
    input  logic        crc_en,
    input  logic        crc_autoclr_off,
    input  logic        batt_low,
    input  logic        ovr_evt,
    input  logic        flush,
    input  logic        lowbat_clr,
    input  logic        drain,
    output logic        overrun,
    output logic        pkt_sent,
    output logic        payload_rdy,
    output logic        crc_ok,
    output logic        low_bat
);

    logic rx_done, pr_set, co_set;
    logic overrun_d, sent_d, payload_d, crc_d, lowbat_d;

    assign rx_done = (mode == MODE_RX) && pkt_done;
    assign pr_set  = rx_done && payload_allowed(crc_en, crc_autoclr_off, crc_good);
    assign co_set  = rx_done && crc_good;

    always_comb begin
        overrun_d = flush ? 1'b0 : (overrun || ovr_evt);
        sent_d    = (mode == MODE_TX) && (pkt_sent || pkt_done);
        lowbat_d  = batt_low || (low_bat && !lowbat_clr);

        if (flush)       payload_d = 1'b0;
        else if (pr_set) payload_d = 1'b1;
        else if (drain)  payload_d = 1'b0;
        else             payload_d = payload_rdy;

        if (flush)       crc_d = 1'b0;
        else if (co_set) crc_d = 1'b1;
        else if (drain)  crc_d = 1'b0;
        else             crc_d = crc_ok;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            overrun     <= 1'b0;
            pkt_sent    <= 1'b0;
            payload_rdy <= 1'b0;
            crc_ok      <= 1'b0;
            low_bat     <= 1'b0;
        end else begin
            overrun     <= overrun_d;
            pkt_sent    <= sent_d;
            payload_rdy <= payload_d;
            crc_ok      <= crc_d;
            low_bat     <= lowbat_d;
        end
    end

    assert_overrun_sticky_R4: assert property (@(posedge clk) disable iff (rst)
        (overrun && !flush) |=> overrun);

    assert_sleep_no_overrun_R4: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_SLEEP && !overrun) |=> !overrun);

    assert_sent_leave_tx_R6: assert property (@(posedge clk) disable iff (rst)
        (mode != MODE_TX) |=> !pkt_sent);

    assert_payload_drain_R9: assert property (@(posedge clk) disable iff (rst)
        (drain && !rx_done) |=> (!payload_rdy && !crc_ok));

    assert_lowbat_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        (low_bat && !lowbat_clr) |=> low_bat);

endmodule

// File: rtl/pkt_fifo_status.sv
module pkt_fifo_status
    import pfs_pkg::*;
#(
    parameter int DEPTH = 66,
    parameter int DW    = 8,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [1:0]    mode,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_en,
    output logic [DW-1:0] rd_data,
    input  logic [CW-1:0] thresh,
    input  logic          pkt_done,
    input  logic          crc_good,
    input  logic          crc_en,
    input  logic          crc_autoclr_off,
    input  logic          batt_low,
    input  logic          irq_wr,
    input  logic [7:0]    irq_wdata,
    output logic [7:0]    status
);

    radio_mode_e  mode_e;
    fifo_status_t st;
    logic [CW-1:0] count;
    logic flush, lowbat_clr, drain, ovr_evt;

    assign mode_e     = radio_mode_e'(mode);
    assign flush      = irq_wr && irq_wdata[W1C_FLUSH_BIT];
    assign lowbat_clr = irq_wr && irq_wdata[W1C_LOWBAT_BIT];

    pfs_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (wr_en),
        .wr_data     (wr_data),
        .rd_en       (rd_en),
        .flush       (flush),
        .ovr_allowed (mode_e != MODE_SLEEP),
        .rd_data     (rd_data),
        .count       (count),
        .drain       (drain),
        .ovr_evt     (ovr_evt)
    );

    pfs_flags u_flags (
        .clk             (clk),
        .rst             (rst),
        .mode            (mode_e),
        .pkt_done        (pkt_done),
        .crc_good        (crc_good),
        .crc_en          (crc_en),
        .crc_autoclr_off (crc_autoclr_off),
        .batt_low        (batt_low),
        .ovr_evt         (ovr_evt),
        .flush           (flush),
        .lowbat_clr      (lowbat_clr),
        .drain           (drain),
        .overrun         (st.overrun),
        .pkt_sent        (st.pkt_sent),
        .payload_rdy     (st.payload_rdy),
        .crc_ok          (st.crc_ok),
        .low_bat         (st.low_bat)
    );

    assign st.full  = (count == CW'(DEPTH));
    assign st.empty = (count == '0);
    assign st.level = (count > thresh);
    assign status   = st;

    assert_full_empty_excl_R2: assert property (@(posedge clk) disable iff (rst)
        !(status[7] && status[6]));

endmodule

// File: tb/pkt_fifo_status_test.sv
module pkt_fifo_status_test;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 66;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] mode = 2'd3;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       rd_en = 1'b0;
    logic [7:0] rd_data;
    logic [6:0] thresh = '0;
    logic       pkt_done = 1'b0;
    logic       crc_good = 1'b0;
    logic       crc_en = 1'b0;
    logic       crc_autoclr_off = 1'b0;
    logic       batt_low = 1'b0;
    logic       irq_wr = 1'b0;
    logic [7:0] irq_wdata = '0;
    logic [7:0] status;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    pkt_fifo_status uut (
        .clk(clk), .rst(rst), .mode(mode), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .thresh(thresh), .pkt_done(pkt_done),
        .crc_good(crc_good), .crc_en(crc_en), .crc_autoclr_off(crc_autoclr_off),
        .batt_low(batt_low), .irq_wr(irq_wr), .irq_wdata(irq_wdata), .status(status)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [7:0] pat(input int i);
        return 8'((i * 37 + 11) & 255);
    endfunction

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    task automatic push(input logic [7:0] b);
        wr_en = 1'b1; wr_data = b;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic pop();
        rd_en = 1'b1;
        tick();
        rd_en = 1'b0;
    endtask

    task automatic w1c(input logic [7:0] d);
        irq_wr = 1'b1; irq_wdata = d;
        tick();
        irq_wr = 1'b0; irq_wdata = '0;
    endtask

    task automatic strobe(input logic en, input logic off, input logic good);
        crc_en = en; crc_autoclr_off = off; crc_good = good; pkt_done = 1'b1;
        tick();
        pkt_done = 1'b0; crc_good = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        report();
    end

    initial begin
        // reset
        tick(); tick();
        rst = 1'b0;
        tick();
        check("R2", "reset status", int'(status), 8'h40);

        // R1 R2 R3: sweep every count against every threshold
        for (int n = 0; n <= DEPTH; n++) begin
            if (n > 0) push(pat(n - 1));
            for (int t = 0; t <= DEPTH; t++) begin
                thresh = 7'(t);
                #1;
                check("R3", "level", int'(status[5]), (n > t) ? 1 : 0);
            end
            thresh = 7'd0;
            #1;
            check("R1", "full", int'(status[7]), (n == DEPTH) ? 1 : 0);
            check("R2", "empty", int'(status[6]), (n == 0) ? 1 : 0);
        end

        // R4: write while full in sleep sets no overrun
        mode = 2'd0;
        push(8'hEE);
        check("R4", "overrun in sleep", int'(status[4]), 0);
        check("R1", "still full", int'(status[7]), 1);

        // R4: write while full in receive sets overrun; sticky
        mode = 2'd3;
        push(8'hDD);
        check("R4", "overrun set", int'(status[4]), 1);
        tick(); tick();
        check("R4", "overrun sticky", int'(status[4]), 1);
        w1c(8'hEF);
        check("R4", "w1c without bit4", int'(status[4]), 1);
        check("R1", "no flush by bit0 write", int'(status[7]), 1);

        // R11 R1: read back in order, discarded writes absent
        for (int i = 0; i < DEPTH; i++) begin
            pop();
            check("R11", "read order", int'(rd_data), int'(pat(i)));
        end
        check("R2", "empty after drain", int'(status[6]), 1);
        pop();
        check("R11", "empty read zero", int'(rd_data), 0);
        push(8'h5A);
        pop();
        check("R11", "pointer kept after empty read", int'(rd_data), 8'h5A);

        // R5: flush with payload/crc set and simultaneous write and read
        push(8'h11); push(8'h22); push(8'h33);
        strobe(1'b1, 1'b0, 1'b1);
        check("R7", "payload set good crc", int'(status[2]), 1);
        check("R8", "crc ok set", int'(status[1]), 1);
        wr_en = 1'b1; wr_data = 8'h99; rd_en = 1'b1;
        w1c(8'h10);
        wr_en = 1'b0; rd_en = 1'b0;
        check("R5", "flush status", int'(status), 8'h40);
        check("R5", "flush read gives zero", int'(rd_data), 0);
        push(8'h77);
        check("R5", "reuse not empty", int'(status[6]), 0);
        pop();
        check("R5", "reuse data", int'(rd_data), 8'h77);

        // R6: packet sent
        mode = 2'd2;
        tick();
        pkt_done = 1'b1; tick(); pkt_done = 1'b0;
        check("R6", "sent set in tx", int'(status[3]), 1);
        tick();
        check("R6", "sent held in tx", int'(status[3]), 1);
        mode = 2'd3;
        tick();
        check("R6", "sent cleared leaving tx", int'(status[3]), 0);
        push(8'h01); push(8'h02);
        strobe(1'b0, 1'b0, 1'b0);
        check("R6", "no sent in rx", int'(status[3]), 0);
        check("R7", "payload crc disabled", int'(status[2]), 1);
        check("R8", "no crc ok on bad crc", int'(status[1]), 0);
        w1c(8'h10);

        // R7 R8: crc gating
        push(8'h01); push(8'h02);
        strobe(1'b1, 1'b0, 1'b0);
        check("R7", "payload blocked bad crc", int'(status[2]), 0);
        check("R8", "crc ok clear bad crc", int'(status[1]), 0);
        strobe(1'b1, 1'b1, 1'b0);
        check("R7", "payload auto-clear-off", int'(status[2]), 1);
        check("R8", "crc ok clear auto-clear-off", int'(status[1]), 0);
        w1c(8'h10);
        push(8'h01); push(8'h02);
        mode = 2'd2;
        strobe(1'b0, 1'b0, 1'b1);
        check("R7", "no payload in tx", int'(status[2]), 0);
        check("R8", "no crc ok in tx", int'(status[1]), 0);
        mode = 2'd1;
        strobe(1'b0, 1'b0, 1'b1);
        check("R7", "no payload in standby", int'(status[2]), 0);
        mode = 2'd3;
        tick();

        // R9: clear on drain
        strobe(1'b1, 1'b0, 1'b1);
        pop();
        check("R9", "payload held one left", int'(status[2]), 1);
        check("R9", "crc held one left", int'(status[1]), 1);
        pop();
        check("R9", "payload cleared on empty", int'(status[2]), 0);
        check("R9", "crc cleared on empty", int'(status[1]), 0);
        check("R2", "empty with drain", int'(status[6]), 1);
        push(8'h44);
        rd_en = 1'b1;
        strobe(1'b1, 1'b0, 1'b1);
        rd_en = 1'b0;
        check("R9", "set wins over drain", int'(status[2]), 1);
        tick();
        check("R9", "cleared next edge", int'(status[2]), 0);

        // R10: low battery
        batt_low = 1'b1; tick(); batt_low = 1'b0;
        check("R10", "lowbat set", int'(status[0]), 1);
        tick();
        check("R10", "lowbat held", int'(status[0]), 1);
        w1c(8'hEE);
        check("R10", "lowbat kept by bit0=0", int'(status[0]), 1);
        w1c(8'h01);
        check("R10", "lowbat cleared", int'(status[0]), 0);
        batt_low = 1'b1;
        w1c(8'h01);
        batt_low = 1'b0;
        check("R10", "set wins over clear", int'(status[0]), 1);

        report();
    end

endmodule